// File: doc/BRIEF.md
# Radio Frame Position Start-Pulse Generator

This block keeps track of the transmit position inside each 10 ms radio frame. It uses three counters: the word within a basic frame, the basic frame within a hyperframe, and the hyperframe within the radio frame. A word-rate enable moves the counters forward. A frame-boundary pulse sends them back to the origin.

Software writes one packed start-position register. When the running position matches all three programmed fields, the block raises a single-cycle start pulse. A data source uses this pulse to begin filling its payload at a known place in the frame. Software may program a position earlier than the payload position it actually wants, so that the latency of the downstream buffering is absorbed. The number of words per basic frame is a parameter, and so are the two frame-level counts.

Top module: `rfpos_start_gen`

## Requirements
- R1: After reset the three position outputs read zero, `startPulse` is low, and the start-position register holds an out-of-range value, so no pulse occurs until software writes the register.
- R2: The word counter increments by one on each cycle with `wordEn` high and `frameStart` low. All counters hold their values when `wordEn` is low.
- R3: On an enable at word `WORDS_PER_BF-1`, the word counter returns to 0 and the basic-frame counter increments.
- R4: On an enable at word `WORDS_PER_BF-1` and basic frame `BASIC_PER_HYPER-1`, the basic-frame counter returns to 0 and the hyperframe counter increments. At hyperframe `HYPER_PER_FRAME-1` the hyperframe counter returns to 0, which starts a new frame.
- R5: `frameStart` high clears all three counters at the next clock edge. It takes priority over `wordEn`.
- R6: A write with `cfgWrEn` high loads the start position from `cfgWrData`. The word index is taken from bits [23:16], the hyperframe from bits [15:8] and the basic frame from bits [7:0]. Bits [31:24] are ignored.
- R7: `startPulse` is high for exactly one cycle. That cycle is the one in which `wordEn` is high, `frameStart` is low, and the current word, basic frame and hyperframe all equal the stored fields.
- R8: A stored position with any field at or above its counter limit never produces a pulse.
- R9: After a pulse, no further pulse occurs until the frame wraps or `frameStart` is seen, even if a later position is written meanwhile.
- R10: A register write affects matching only from the following cycle. No pulse is produced in a cycle with `frameStart` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wordEn | input | 1 | Word-rate enable that advances the position |
| frameStart | input | 1 | Radio-frame boundary; clears the position |
| cfgWrEn | input | 1 | Write strobe for the start-position register |
| cfgWrData | input | 32 | Packed start position: word [23:16], hyperframe [15:8], basic frame [7:0] |
| startPulse | output | 1 | One-cycle start indication |
| curHyper | output | 8 | Current hyperframe number |
| curBasic | output | 8 | Current basic frame number |
| curWord | output | 8 | Current word index in the basic frame |

## Verification
A bad counter shows up on the position outputs in the cycle after the enable that produced it. It also moves the pulse away from the cycle the bench predicts for the programmed position. A stale or lost "already fired" state shows only later, as a missing pulse or a second pulse in the same frame. The bench therefore sweeps every position of a small frame as the target and compares the pulse and the position in every cycle. It also covers rewrites made after firing, out-of-range fields, and boundary pulses that coincide with an enable.

// File: rtl/rfpos_pkg.sv
package rfpos_pkg;
  typedef struct packed {
    logic clear;
    logic advance;
  } ctrlStrobes_t;

  // layout mirrors the start-position register bits [23:0]
  typedef struct packed {
    logic [7:0] word;
    logic [7:0] hyper;
    logic [7:0] basic;
  } framePos_t;
endpackage

// File: rtl/rfpos_datapath.sv
module rfpos_datapath
  import rfpos_pkg::*;
#(
  parameter int WORDS_PER_BF    = 16,
  parameter int BASIC_PER_HYPER = 256,
  parameter int HYPER_PER_FRAME = 150
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ctrlStrobes_t strobes,
  input  logic         cfgWrEn,
  input  logic [31:0]  cfgWrData,
  output framePos_t    curPos,
  output logic         posMatch,
  output logic         frameLast
);
  localparam logic [7:0] WORD_LAST  = 8'(WORDS_PER_BF - 1);
  localparam logic [7:0] BASIC_LAST = 8'(BASIC_PER_HYPER - 1);
  localparam logic [7:0] HYPER_LAST = 8'(HYPER_PER_FRAME - 1);
  localparam logic [8:0] WORD_LIM   = 9'(WORDS_PER_BF);
  localparam logic [8:0] BASIC_LIM  = 9'(BASIC_PER_HYPER);
  localparam logic [8:0] HYPER_LIM  = 9'(HYPER_PER_FRAME);

  framePos_t posReg;
  framePos_t offsetReg;
  logic wordLast, basicLast, hyperLast, offsetValid;

  assign wordLast  = (posReg.word  == WORD_LAST);
  assign basicLast = (posReg.basic == BASIC_LAST);
  assign hyperLast = (posReg.hyper == HYPER_LAST);
  assign frameLast = wordLast & basicLast & hyperLast;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      posReg <= '0;
    end else if (strobes.clear) begin
      posReg <= '0;
    end else if (strobes.advance) begin
      posReg.word <= wordLast ? 8'd0 : posReg.word + 8'd1;
      if (wordLast)
        posReg.basic <= basicLast ? 8'd0 : posReg.basic + 8'd1;
      if (wordLast && basicLast)
        posReg.hyper <= hyperLast ? 8'd0 : posReg.hyper + 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      offsetReg <= '1;
    else if (cfgWrEn)
      offsetReg <= framePos_t'(cfgWrData[23:0]);
  end

  assign offsetValid = ({1'b0, offsetReg.word}  < WORD_LIM)  &&
                       ({1'b0, offsetReg.basic} < BASIC_LIM) &&
                       ({1'b0, offsetReg.hyper} < HYPER_LIM);
  assign posMatch = offsetValid && (posReg == offsetReg);
  assign curPos   = posReg;

  assert_pos_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, curPos.word} < WORD_LIM) && ({1'b0, curPos.basic} < BASIC_LIM) &&
    ({1'b0, curPos.hyper} < HYPER_LIM));
  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clear |=> (curPos == '0));
  assert_word_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.advance && !strobes.clear && !wordLast) |=>
      (curPos.word == $past(curPos.word) + 8'd1));
  assert_word_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.advance && !strobes.clear && wordLast && !basicLast) |=>
      (curPos.word == 8'd0 && curPos.basic == $past(curPos.basic) + 8'd1));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.advance && !strobes.clear) |=> $stable(curPos));
endmodule

// File: rtl/rfpos_control.sv
module rfpos_control
  import rfpos_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wordEn,
  input  logic         frameStart,
  input  logic         posMatch,
  input  logic         frameLast,
  output ctrlStrobes_t strobes,
  output logic         startPulse
);
  logic firedThisFrame;

  always_comb begin
    strobes.clear   = frameStart;
    strobes.advance = wordEn & ~frameStart;
  end

  assign startPulse = strobes.advance & posMatch & ~firedThisFrame;

  always_ff @(posedge clk) begin
    if (!rst_n)
      firedThisFrame <= 1'b0;
    else if (strobes.clear)
      firedThisFrame <= 1'b0;
    else if (strobes.advance && frameLast)
      firedThisFrame <= 1'b0;
    else if (startPulse)
      firedThisFrame <= 1'b1;
  end

  assert_pulse_qualified_R10: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |-> (wordEn && !frameStart));
  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |=> !startPulse);
  assert_once_per_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (startPulse && !frameLast) |=> (firedThisFrame && !startPulse));
endmodule

// File: rtl/rfpos_start_gen.sv
module rfpos_start_gen
  import rfpos_pkg::*;
#(
  parameter int WORDS_PER_BF    = 16,
  parameter int BASIC_PER_HYPER = 256,
  parameter int HYPER_PER_FRAME = 150
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wordEn,
  input  logic        frameStart,
  input  logic        cfgWrEn,
  input  logic [31:0] cfgWrData,
  output logic        startPulse,
  output logic [7:0]  curHyper,
  output logic [7:0]  curBasic,
  output logic [7:0]  curWord
);
  ctrlStrobes_t strobes;
  framePos_t    curPos;
  logic         posMatch, frameLast;

  rfpos_control u_ctrl (
    .clk(clk), .rst_n(rst_n), .wordEn(wordEn), .frameStart(frameStart),
    .posMatch(posMatch), .frameLast(frameLast),
    .strobes(strobes), .startPulse(startPulse)
  );

  rfpos_datapath #(
    .WORDS_PER_BF(WORDS_PER_BF), .BASIC_PER_HYPER(BASIC_PER_HYPER),
    .HYPER_PER_FRAME(HYPER_PER_FRAME)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .curPos(curPos), .posMatch(posMatch),
    .frameLast(frameLast)
  );

  assign curHyper = curPos.hyper;
  assign curBasic = curPos.basic;
  assign curWord  = curPos.word;
endmodule

// File: tb/sim_rfpos_start_gen.sv
module sim_rfpos_start_gen;
  localparam int NW = 4, NB = 4, NH = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wordEn = 1'b0, frameStart = 1'b0, cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic startPulse;
  logic [7:0] curHyper, curBasic, curWord;

  int checks = 0, errors = 0;
  bit finished = 0;
  int mW = 0, mB = 0, mH = 0, oW = 255, oB = 255, oH = 255;
  bit mFired = 0;

  always #5 clk = ~clk;

  rfpos_start_gen #(.WORDS_PER_BF(NW), .BASIC_PER_HYPER(NB), .HYPER_PER_FRAME(NH)) u0 (
    .clk(clk), .rst_n(rst_n), .wordEn(wordEn), .frameStart(frameStart),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .startPulse(startPulse),
    .curHyper(curHyper), .curBasic(curBasic), .curWord(curWord));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int packPos(input int w, input int h, input int b);
    return (w << 16) | (h << 8) | b;
  endfunction

  task automatic step(input logic en, input logic fs, input logic wr,
                      input logic [31:0] d, input string tag);
    bit expPulse, valid;
    string ptag;
    @(negedge clk);
    wordEn = en; frameStart = fs; cfgWrEn = wr; cfgWrData = d;
    #1;
    valid = (oW < NW) && (oB < NB) && (oH < NH);
    expPulse = en && !fs && valid && mW == oW && mB == oB && mH == oH && !mFired;
    check(startPulse === expPulse, tag, int'(startPulse), int'(expPulse));
    @(posedge clk);
    ptag = "R2";
    if (fs) begin
      mW = 0; mB = 0; mH = 0; mFired = 0; ptag = "R5";
    end else if (en) begin
      if (expPulse) mFired = 1;
      if (mW == NW - 1) begin
        mW = 0; ptag = "R3";
        if (mB == NB - 1) begin
          mB = 0; ptag = "R4";
          if (mH == NH - 1) begin mH = 0; mFired = 0; end
          else mH++;
        end else mB++;
      end else mW++;
    end
    if (wr) begin oW = int'(d[23:16]); oH = int'(d[15:8]); oB = int'(d[7:0]); end
    #1;
    check({curWord, curHyper, curBasic} == 24'(packPos(mW, mH, mB)), ptag,
          int'({curWord, curHyper, curBasic}), packPos(mW, mH, mB));
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    // R1 reset state
    check({curWord, curHyper, curBasic} == 24'd0, "R1", int'({curWord, curHyper, curBasic}), 0);
    check(startPulse == 1'b0, "R1", int'(startPulse), 0);
    for (int k = 0; k < 60; k++) step(1'b1, 1'b0, 1'b0, 32'd0, "R1");

    // sweep every target position; junk in bits [31:24] (R6), single pulse (R7)
    for (int t = 0; t < NW * NB * NH; t++) begin
      int tw, tb, th;
      tw = t % NW; tb = (t / NW) % NB; th = t / (NW * NB);
      step(1'b0, 1'b0, 1'b1, 32'((t + 7) << 24) | 32'(packPos(tw, th, tb)), "R6");
      step(1'b0, 1'b1, 1'b0, 32'd0, "R5");
      for (int k = 0; k < 70; k++) step((k % 5) != 3, 1'b0, 1'b0, 32'd0, "R7");
    end

    // out-of-range fields never fire (R8)
    for (int v = 0; v < 4; v++) begin
      int d;
      d = (v == 0) ? packPos(NW, 0, 0) : (v == 1) ? packPos(0, 0, NB) :
          (v == 2) ? packPos(0, NH, 0) : packPos(255, 255, 255);
      step(1'b0, 1'b1, 1'b1, 32'(d), "R8");
      for (int k = 0; k < NW * NB * NH + 5; k++) step(1'b1, 1'b0, 1'b0, 32'd0, "R8");
    end

    // rewrite to a later position after firing (R9)
    step(1'b0, 1'b1, 1'b1, 32'(packPos(0, 0, 1)), "R9");
    for (int k = 0; k < NW + 1; k++) step(1'b1, 1'b0, 1'b0, 32'd0, "R9");
    step(1'b0, 1'b0, 1'b1, 32'(packPos(0, 1, 0)), "R9");
    for (int k = 0; k < NW * NB * NH + 4; k++) step(1'b1, 1'b0, 1'b0, 32'd0, "R9");

    // frameStart with enable suppresses pulse; write effective next cycle (R10)
    step(1'b0, 1'b1, 1'b1, 32'd0, "R10");
    step(1'b1, 1'b1, 1'b0, 32'd0, "R10");
    step(1'b1, 1'b0, 1'b0, 32'd0, "R10");
    step(1'b1, 1'b0, 1'b1, 32'(packPos(2, 0, 0)), "R10");
    step(1'b1, 1'b0, 1'b0, 32'd0, "R10");
    for (int k = 0; k < NW * NB * NH; k++) step(1'b1, 1'b0, 1'b0, 32'd0, "R10");
    // mid-frame boundary
    for (int k = 0; k < 9; k++) step(1'b1, 1'b0, 1'b0, 32'd0, "R5");
    step(1'b1, 1'b1, 1'b0, 32'd0, "R5");
    step(1'b0, 1'b0, 1'b0, 32'd0, "R2");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule